// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the device side of a small serial nonvolatile byte memory. An external master selects it with an active-low chip select, clocks commands and data in on `si` and receives read data on `so`. The first byte of each selection is the command. Some commands carry the top address bit inside the command byte itself. The block runs array reads, page writes, status register reads and writes, and write enable or disable. It honours a pause input, a write-protect pin and a block-protection level kept in the status register.

All serial inputs are treated as already synchronous to `clk`, and the block finds SCK edges by comparing samples taken on successive clock cycles. A write is collected in a page buffer and committed when chip select goes high. Committing starts a self-timed busy period of `WRITE_CYCLES` clock cycles. `so_oe` marks the cycles in which `so` would be driven. When it is low, the pin is high-impedance.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Input bits are sampled on rising SCK and output bits change on falling SCK, most significant bit first. This holds whether SCK idles low or idles high while chip select falls.
- R2: While `cs_n` is high, SCK and SI activity has no effect and `so_oe` is 0.
- R3: Opcode `0000_A011` is a read. A is address bit 8, and the next byte is address bits 7..0. Read data streams from consecutive addresses and wraps from 0x1FF to 0x000. After reset every location reads 0xFF.
- R4: Opcode `0000_A010` is a write. Data bytes fill one 8-byte page, the low 3 address bits advance and wrap inside the page, and the page is committed only if chip select rises after a whole number of data bytes (at least one).
- R5: Opcode 0x06 sets the write-enable latch and 0x04 clears it. A data or status write commits only while the latch is set, and the latch clears when the write cycle ends.
- R6: Opcode 0x05 returns the status byte, repeated for as long as clocking continues. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect level, and bits 7:4 read 0.
- R7: After a commit, busy stays 1 for `WRITE_CYCLES` clocks. During that time only 0x05 is accepted, and any other opcode leaves `so_oe` low for the rest of the selection.
- R8: Opcode 0x01 writes the protect level from bits 3:2 of the following byte, and the other bits of that byte are ignored. The levels are 0 for none, 1 for 0x180–0x1FF, 2 for 0x100–0x1FF and 3 for the whole array. A data write to a protected page is dropped, and the latch stays set.
- R9: If `wp_n` is low at any point while selected, or at the commit, the write is dropped. Dropping `wp_n` after the commit has no effect on that write.
- R10: An opcode outside the set above makes the block ignore SI and keep `so_oe` low until the next fall of `cs_n`.
- R11: Lowering `hold_n` while SCK is low pauses the transfer. While paused, SCK and SI are ignored and `so_oe` is 0. Raising `hold_n` while SCK is low resumes the transfer at the same bit.
- R12: After reset `so_oe` is 0 and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | High when `so` is driven |

## Verification
The bench builds the block with `PAGE_W` = 3 and `WRITE_CYCLES` = 400. With a busy period of 400 cycles, a status read issued right after a commit lands inside the busy window, and so does a read attempted in that window. Each full busy period still ends within a short wait. The default page width keeps the 8-byte wrap, so a 10-byte burst overwrites the first two offsets it wrote.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_RD, S_WR, S_SR, S_STAT, S_IGN} st_t;

  st_t            st;
  logic [7:0]     mem  [DEPTH];
  logic [7:0]     pbuf [PAGE];
  logic [PAGE-1:0] pvld;
  logic [AW-1:0]  addr;
  logic [6:0]     sr;
  logic [2:0]     bcnt;
  logic [7:0]     osr;
  logic [1:0]     bp, bp_new;
  logic [CW-1:0]  wcnt;
  logic           sck_q, cs_q, held, rd_op, wel, busy, wp_hit, sr_got, so_r;

  function automatic logic locked(input logic [1:0] lvl, input logic [1:0] top);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return &top;
      2'd2:    return top[1];
      default: return 1'b1;
    endcase
  endfunction

  wire       active  = !cs_n && !held;
  wire       rise    = active && sck && !sck_q;
  wire       fall    = active && !sck && sck_q;
  wire [7:0] byte_in = {sr, si};
  wire       done    = rise && (bcnt == 3'd7);
  wire [7:0] status  = {4'b0, bp, wel, busy};
  wire       commit  = cs_n && !cs_q && bcnt == 3'd0 && wel && wp_n && !wp_hit;
  wire       wr_go   = commit && st == S_WR && |pvld && !locked(bp, addr[AW-1:AW-2]);
  wire       sr_go   = commit && st == S_SR && sr_got;

  assign so    = so_r;
  assign so_oe = active && (st == S_RD || st == S_STAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    else if (wr_go)
      for (int i = 0; i < PAGE; i++)
        if (pvld[i]) mem[{addr[AW-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];

  always_ff @(posedge clk)
    if (!cs_n && done && st == S_WR) pbuf[addr[PAGE_W-1:0]] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; pvld <= '0; addr <= '0; sr <= '0; bcnt <= '0; osr <= '0;
      bp <= '0; bp_new <= '0; wcnt <= '0; sck_q <= 1'b0; cs_q <= 1'b1;
      held <= 1'b0; rd_op <= 1'b0; wel <= 1'b0; busy <= 1'b0;
      wp_hit <= 1'b0; sr_got <= 1'b0; so_r <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n)      wp_hit <= 1'b0;
      else if (!wp_n) wp_hit <= 1'b1;
      if (cs_n)      held <= 1'b0;
      else if (!sck) held <= !hold_n;

      if (busy) begin
        if (wcnt == '0) begin busy <= 1'b0; wel <= 1'b0; end
        else wcnt <= wcnt - 1'b1;
      end
      if (wr_go || sr_go) begin busy <= 1'b1; wcnt <= CW'(WRITE_CYCLES - 1); end
      if (sr_go) bp <= bp_new;

      if (cs_n) begin
        st <= S_CMD; bcnt <= '0; pvld <= '0; sr_got <= 1'b0;
      end else begin
        if (rise) begin sr <= byte_in[6:0]; bcnt <= bcnt + 1'b1; end
        if (fall) begin so_r <= osr[7]; osr <= {osr[6:0], 1'b0}; end
        if (done)
          case (st)
            S_CMD: begin
              st <= S_IGN;
              if (byte_in == 8'h05) begin st <= S_STAT; osr <= status; end
              else if (!busy) begin
                if (byte_in == 8'h06) wel <= 1'b1;
                else if (byte_in == 8'h04) wel <= 1'b0;
                else if (byte_in == 8'h01) st <= S_SR;
                else if ((byte_in & 8'hF7) == 8'h03) begin
                  st <= S_ADDR; rd_op <= 1'b1; addr[AW-1] <= byte_in[3];
                end else if ((byte_in & 8'hF7) == 8'h02) begin
                  st <= S_ADDR; rd_op <= 1'b0; addr[AW-1] <= byte_in[3];
                end
              end
            end
            S_ADDR: begin
              addr[7:0] <= byte_in;
              if (rd_op) begin st <= S_RD; osr <= mem[{addr[AW-1], byte_in}]; end
              else st <= S_WR;
            end
            S_RD: begin addr <= addr + 1'b1; osr <= mem[addr + 1'b1]; end
            S_WR: begin
              pvld[addr[PAGE_W-1:0]] <= 1'b1;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            end
            S_SR:   begin bp_new <= byte_in[3:2]; sr_got <= 1'b1; end
            S_STAT: osr <= status;
            default: ;
          endcase
      end
    end
endmodule

module spi_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wp_n,
  input logic       so_oe,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp
);
  assert_commit_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  assert_wel_clears_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_commit_on_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n) && !$past(cs_n, 2));
  assert_wp_blocks_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wp_n));
  assert_level_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bp));
  assert_quiet_after_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && $past(cs_n) |-> !so_oe);
endmodule

bind spi_eeprom_slave spi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
  .so_oe(so_oe), .busy(busy), .wel(wel), .bp(bp)
);

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
  localparam int TWC = 400;
  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'h3C}, {9'h001, 8'hA5}, {9'h0FF, 8'h5A},
    {9'h100, 8'hC3}, {9'h17F, 8'h81}, {9'h1FF, 8'h7E}};

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1, so, so_oe;
  logic mode3 = 1'b0, oe_any = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] d, s;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_eeprom_slave #(.PAGE_W(3), .WRITE_CYCLES(TWC)) i_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int hi, input int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      sck = 1'b0; si = tx[i]; tick(4);
      rx[i] = so; oe_any |= so_oe;
      sck = 1'b1; tick(4);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = '0;
    xbits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic sel; sck = mode3; tick(2); cs_n = 1'b0; tick(2); oe_any = 1'b0; endtask
  task automatic desel; sck = mode3; tick(2); cs_n = 1'b1; tick(4); endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel; xfer(op, r); desel;
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    sel; xfer(8'h05, r); xfer(8'h00, st); desel;
  endtask

  task automatic rd1(input logic [8:0] a, output logic [7:0] v);
    logic [7:0] r;
    sel; xfer({4'b0, a[8], 3'b011}, r); xfer(a[7:0], r); xfer(8'h00, v); desel;
  endtask

  task automatic write_n(input logic [8:0] a, input int n);
    logic [7:0] r;
    sel; xfer({4'b0, a[8], 3'b010}, r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(wbuf[k], r);
    desel;
  endtask

  task automatic wr1(input logic [8:0] a, input logic [7:0] v, input logic en);
    if (en) op1(8'h06);
    wbuf[0] = v; write_n(a, 1); tick(TWC + 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %h expected %h", 8'h00, 8'h01);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    tick(5); rst_n = 1'b1; tick(3);
    chk("R12 so_oe after reset", {7'b0, so_oe}, 8'h00);
    rdsr(s); chk("R12 R6 status after reset", s, 8'h00);
    rd1(9'h000, d); chk("R3 erased read", d, 8'hFF);

    for (int v = 0; v < 6; v++) begin
      wr1(VEC[v][16:8], VEC[v][7:0], 1'b1);
      rd1(VEC[v][16:8], d); chk("R3 R4 vector readback", d, VEC[v][7:0]);
    end

    op1(8'h06); wbuf[0] = 8'h11; write_n(9'h010, 1);
    rdsr(s); chk("R7 R6 busy status", s, 8'h03);
    sel; xfer(8'h03, r); xfer(8'h10, r); xfer(8'h00, r); desel;
    chk("R7 read ignored while busy", {7'b0, oe_any}, 8'h00);
    tick(TWC + 10);
    rdsr(s); chk("R5 latch cleared after write", s, 8'h00);
    rd1(9'h010, d); chk("R4 busy-window write landed", d, 8'h11);

    sel; xfer(8'h0B, r); xfer(8'hFF, r); xfer(8'h00, d); xfer(8'h00, s); desel;
    chk("R3 read at 0x1FF", d, 8'h7E);
    chk("R3 read wraps to 0x000", s, 8'h3C);

    op1(8'h06);
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h40 + 8'(k);
    write_n(9'h0A5, 10); tick(TWC + 10);
    sel; xfer(8'h03, r); xfer(8'hA0, r);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] e;
      e = (k == 8) ? 8'hFF : (k <= 4) ? 8'h43 + 8'(k) : (k == 5) ? 8'h48 : (k == 6) ? 8'h49 : 8'h42;
      xfer(8'h00, d); chk("R4 page wrap contents", d, e);
    end
    desel;

    wr1(9'h020, 8'h99, 1'b0);
    rd1(9'h020, d); chk("R5 write without latch dropped", d, 8'hFF);
    op1(8'h06); op1(8'h04); wr1(9'h021, 8'h98, 1'b0);
    rd1(9'h021, d); chk("R5 write after disable dropped", d, 8'hFF);

    op1(8'h06);
    sel; xfer(8'h02, r); xfer(8'h30, r); xfer(8'h77, r); xbits(8'hE0, 7, 5, r); desel;
    tick(TWC + 10);
    rd1(9'h030, d); chk("R4 partial byte not committed", d, 8'hFF);
    rdsr(s); chk("R5 latch kept without commit", s, 8'h02);

    sel; xfer(8'h02, r); xfer(8'h31, r); wp_n = 1'b0; tick(2); wp_n = 1'b1;
    xfer(8'h55, r); desel; tick(TWC + 10);
    rd1(9'h031, d); chk("R9 write aborted by wp pulse", d, 8'hFF);
    wp_n = 1'b0; wbuf[0] = 8'h56; write_n(9'h032, 1); wp_n = 1'b1; tick(TWC + 10);
    rd1(9'h032, d); chk("R9 write blocked by wp low", d, 8'hFF);
    wbuf[0] = 8'h66; write_n(9'h033, 1); wp_n = 1'b0; tick(TWC + 10); wp_n = 1'b1;
    rd1(9'h033, d); chk("R9 wp after commit no effect", d, 8'h66);

    op1(8'h06); sel; xfer(8'h01, r); xfer(8'hF4, r); desel; tick(TWC + 10);
    rdsr(s); chk("R8 level 1 set, other bits ignored", s, 8'h04);
    wr1(9'h1FF, 8'h12, 1'b1);
    rd1(9'h1FF, d); chk("R8 upper quarter protected", d, 8'h7E);
    rdsr(s); chk("R8 latch stays after blocked write", s, 8'h06);
    wr1(9'h17F, 8'h34, 1'b0);
    rd1(9'h17F, d); chk("R8 below quarter writable", d, 8'h34);
    op1(8'h06); sel; xfer(8'h01, r); xfer(8'h08, r); desel; tick(TWC + 10);
    wr1(9'h100, 8'h57, 1'b1);
    rd1(9'h100, d); chk("R8 upper half protected", d, 8'hC3);
    op1(8'h06); sel; xfer(8'h01, r); xfer(8'h0C, r); desel; tick(TWC + 10);
    wr1(9'h000, 8'h77, 1'b0);
    rd1(9'h000, d); chk("R8 whole array protected", d, 8'h3C);
    op1(8'h06); sel; xfer(8'h01, r); xfer(8'h00, r); desel; tick(TWC + 10);
    rdsr(s); chk("R8 level cleared", s, 8'h00);

    sel; xfer(8'hFF, r); xfer(8'h06, r); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); desel;
    chk("R10 so silent after bad opcode", {7'b0, oe_any}, 8'h00);
    rdsr(s); chk("R10 later opcode ignored", s, 8'h00);
    rd1(9'h000, d); chk("R10 recovery after reselect", d, 8'h3C);

    cs_n = 1'b1; oe_any = 1'b0;
    xbits(8'h06, 7, 0, r);
    chk("R2 so_oe low while deselected", {7'b0, oe_any}, 8'h00);
    rdsr(s); chk("R2 clocks while deselected ignored", s, 8'h00);

    mode3 = 1'b1; sck = 1'b1; tick(4);
    rd1(9'h010, d); chk("R1 idle-high clock read", d, 8'h11);
    wr1(9'h011, 8'h22, 1'b1);
    rd1(9'h011, d); chk("R1 idle-high clock write", d, 8'h22);
    mode3 = 1'b0; sck = 1'b0; tick(4);

    sel; xfer(8'h03, r); xfer(8'h00, r);
    sck = 1'b0; tick(3); hold_n = 1'b0; tick(3);
    chk("R11 so_oe low during pause", {7'b0, so_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin si = 1'b1; sck = 1'b1; tick(4); sck = 1'b0; tick(4); end
    hold_n = 1'b1; tick(3);
    xfer(8'h00, d); chk("R11 read resumes same bit", d, 8'h3C);
    xfer(8'h00, d); chk("R11 read continues", d, 8'hA5);
    desel;
    op1(8'h06);
    sel; xfer(8'h02, r); xfer(8'h40, r); xbits(8'hA6, 7, 4, r);
    sck = 1'b0; tick(3); hold_n = 1'b0; tick(3);
    for (int k = 0; k < 3; k++) begin si = 1'b0; sck = 1'b1; tick(4); sck = 1'b0; tick(4); end
    hold_n = 1'b1; tick(3);
    xbits(8'hA6, 3, 0, r); desel; tick(TWC + 10);
    rd1(9'h040, d); chk("R11 SI ignored during pause", d, 8'hA6);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule